// File: doc/BRIEF.md
# Network Device Power State Controller

This block follows the bus power-management state of an integrated network controller and gates the controller's bus activity to match. The fully powered state is split into two substates. Bus reset leaves the block in an uninitialized substate. Programming any base-address register with a non-zero value moves it to the active substate. Host writes to a two-bit power-state field move it among the four device states.

Ordinary, non-configuration bus accesses are claimed only while the device is fully powered. Wake sources are a wake-packet match and a link status change. They set a status bit that drives an active-low power management event output when the wake-enable bit is set. The output stays asserted until software writes one to clear the status. Whenever the controller is mastering cycles on the bus, it raises a request that keeps the bus clock running.

Top module: `nic_pwr_ctrl`

## Requirements
- R1: `pwrState` encodes the state as 0 = D0 uninitialized, 1 = D0 active, 2 = D1, 3 = D2, 4 = D3. A power-state write with `pmStateWr` of 01, 10 or 11 moves the block to D1, D2 or D3 at the next clock edge, from any state.
- R2: While `rstN` is low, and at the edge where it is released, the block is in D0 uninitialized with the wake status and wake enable cleared, so `pmeN` is high.
- R3: In D0 uninitialized, a write of a non-zero value to base-address register 0, 1 or 2 (`barSel` 0 to 2) moves the block to D0 active at the next edge. A zero write, or a write to `barSel` 3, leaves it in D0 uninitialized.
- R4: A power-state write of 00 from D1, D2 or D3 returns the block to D0 active if any base-address register holds a non-zero value, and otherwise to D0 uninitialized.
- R5: `accessEn` equals `busReq` in the same cycle while the state is D0 uninitialized or D0 active, and is low in D1, D2 and D3.
- R6: `wakeMatch` is a wake event in every state. `linkChange` is a wake event in every state except D0 uninitialized. A wake event sets the wake status at the next edge.
- R7: `pmeN` is low exactly when both the wake status and the wake enable are set. Once low, it stays low until a power-state write clears the status or clears the enable.
- R8: A power-state write with `pmeStsClr` set clears the wake status at the next edge, unless a wake event arrives in the same cycle, in which case the status stays set. The same write loads the wake enable from `pmeEnWr`.
- R9: `clkKeep` is high in the same cycle whenever `masterReq` is high, in every state.
- R10: A power-state write of 00 while already in D0 uninitialized or D0 active leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low bus reset |
| barWrite | input | 1 | Configuration write to a base-address register |
| barSel | input | BAR_SEL_W | Which base-address register is written |
| barWrData | input | BAR_W | Value written to the base-address register |
| pmWrite | input | 1 | Configuration write to the power-management control/status field |
| pmStateWr | input | 2 | Power-state field value written (00 = D0 .. 11 = D3) |
| pmeEnWr | input | 1 | Wake-enable bit written |
| pmeStsClr | input | 1 | Write-one-to-clear of the wake status |
| linkChange | input | 1 | Link status change pulse |
| wakeMatch | input | 1 | Wake-packet match pulse |
| busReq | input | 1 | Non-configuration bus access aimed at the device |
| masterReq | input | 1 | Controller is driving cycles on the bus |
| pwrState | output | 3 | Current power state |
| accessEn | output | 1 | Non-configuration access is claimed |
| pmeN | output | 1 | Active-low power management event |
| clkKeep | output | 1 | Request to keep the bus clock running |

## Verification
Writes to the state field and to the base-address registers move `pwrState` one edge after the cycle that carries them. A wake event or a status clear shows on `pmeN` one edge later. `accessEn` and `clkKeep` follow their requests within the same cycle. The bench drives inputs on the falling edge and compares every output against its reference model two nanoseconds later, before the next rising edge, while those inputs are still held. The model's state is advanced only after the rising edge, so each registered result is checked in the first cycle it is due, and each combinational result in the cycle of its request.

// File: rtl/nic_pwr_pkg.sv
package nic_pwr_pkg;

  typedef enum logic [2:0] {
    PS_D0U = 3'd0,
    PS_D0A = 3'd1,
    PS_D1  = 3'd2,
    PS_D2  = 3'd3,
    PS_D3  = 3'd4
  } pwrState_e;

  // strobes from the state control to the datapath
  typedef struct packed {
    logic inD0;       // fully powered, either substate
    logic linkArmed;  // link change counts as a wake source
  } pwrStrobe_t;

endpackage

// File: rtl/nic_pwr_ctl.sv
module nic_pwr_ctl
  import nic_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pmWrite,
  input  logic [1:0] pmStateWr,
  input  logic       barProgram,
  input  logic       barAny,
  output pwrState_e  state,
  output pwrStrobe_t strobe
);

  pwrState_e stateNext;
  logic      inD0;

  assign inD0 = (state == PS_D0U) || (state == PS_D0A);

  always_comb begin
    stateNext = state;
    if (pmWrite) begin
      unique case (pmStateWr)
        2'b00:   if (!inD0) stateNext = barAny ? PS_D0A : PS_D0U;
        2'b01:   stateNext = PS_D1;
        2'b10:   stateNext = PS_D2;
        default: stateNext = PS_D3;
      endcase
    end else if (state == PS_D0U && barProgram) begin
      stateNext = PS_D0A;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_D0U;
    else       state <= stateNext;
  end

  assign strobe.inD0      = inD0;
  assign strobe.linkArmed = (state != PS_D0U);

  AST_RESET_D0U: assert property (@(posedge clk) !rstN |=> state == PS_D0U); // R2

  AST_BAR_ACTIVATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_D0U && barProgram && !pmWrite) |=> state == PS_D0A); // R3

  AST_LOW_STATE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pmWrite && pmStateWr == 2'b11) |=> state == PS_D3); // R1

  AST_D0_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pmWrite && pmStateWr == 2'b00 && inD0) |=> $stable(state)); // R10

  AST_RETURN_D0: assert property (@(posedge clk) disable iff (!rstN)
    (pmWrite && pmStateWr == 2'b00 && !inD0 && barAny) |=> state == PS_D0A); // R4

endmodule

// File: rtl/nic_pwr_dp.sv
module nic_pwr_dp
  import nic_pwr_pkg::*;
#(
  parameter int NUM_BARS  = 3,
  parameter int BAR_W     = 32,
  parameter int BAR_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 barWrite,
  input  logic [BAR_SEL_W-1:0] barSel,
  input  logic [BAR_W-1:0]     barWrData,
  input  logic                 pmWrite,
  input  logic                 pmeEnWr,
  input  logic                 pmeStsClr,
  input  logic                 linkChange,
  input  logic                 wakeMatch,
  input  logic                 busReq,
  input  logic                 masterReq,
  input  pwrStrobe_t           strobe,
  output logic                 barProgram,
  output logic                 barAny,
  output logic                 accessEn,
  output logic                 pmeN,
  output logic                 clkKeep
);

  logic [NUM_BARS-1:0] barSet;
  logic                barValid;
  logic                wakeEvt;
  logic                pmeSts;
  logic                pmeEn;

  assign barValid   = int'(barSel) < NUM_BARS;
  assign barProgram = barWrite && barValid && (|barWrData);

  for (genvar g = 0; g < NUM_BARS; g++) begin : gBar
    always_ff @(posedge clk) begin
      if (!rstN)
        barSet[g] <= 1'b0;
      else if (barWrite && barSel == BAR_SEL_W'(g))
        barSet[g] <= |barWrData;
    end
  end

  assign barAny = |barSet;

  assign wakeEvt = wakeMatch || (linkChange && strobe.linkArmed);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmeSts <= 1'b0;
      pmeEn  <= 1'b0;
    end else begin
      if (wakeEvt)                    pmeSts <= 1'b1;
      else if (pmWrite && pmeStsClr)  pmeSts <= 1'b0;
      if (pmWrite)                    pmeEn  <= pmeEnWr;
    end
  end

  assign pmeN     = !(pmeSts && pmeEn);
  assign accessEn = busReq && strobe.inD0;
  assign clkKeep  = masterReq;

  AST_PME_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (!pmeN && !pmWrite) |=> !pmeN); // R7

  AST_PME_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (pmWrite && pmeStsClr && !wakeMatch && !linkChange) |=> pmeN); // R8

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wakeMatch && pmeEn && !pmWrite) |=> !pmeN); // R6

  AST_CLK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    masterReq |-> clkKeep); // R9

endmodule

// File: rtl/nic_pwr_ctrl.sv
module nic_pwr_ctrl
  import nic_pwr_pkg::*;
#(
  parameter int NUM_BARS  = 3,
  parameter int BAR_W     = 32,
  parameter int BAR_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 barWrite,
  input  logic [BAR_SEL_W-1:0] barSel,
  input  logic [BAR_W-1:0]     barWrData,
  input  logic                 pmWrite,
  input  logic [1:0]           pmStateWr,
  input  logic                 pmeEnWr,
  input  logic                 pmeStsClr,
  input  logic                 linkChange,
  input  logic                 wakeMatch,
  input  logic                 busReq,
  input  logic                 masterReq,
  output logic [2:0]           pwrState,
  output logic                 accessEn,
  output logic                 pmeN,
  output logic                 clkKeep
);

  pwrState_e  state;
  pwrStrobe_t strobe;
  logic       barProgram;
  logic       barAny;

  nic_pwr_ctl i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .pmWrite    (pmWrite),
    .pmStateWr  (pmStateWr),
    .barProgram (barProgram),
    .barAny     (barAny),
    .state      (state),
    .strobe     (strobe)
  );

  nic_pwr_dp #(
    .NUM_BARS  (NUM_BARS),
    .BAR_W     (BAR_W),
    .BAR_SEL_W (BAR_SEL_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .barWrite   (barWrite),
    .barSel     (barSel),
    .barWrData  (barWrData),
    .pmWrite    (pmWrite),
    .pmeEnWr    (pmeEnWr),
    .pmeStsClr  (pmeStsClr),
    .linkChange (linkChange),
    .wakeMatch  (wakeMatch),
    .busReq     (busReq),
    .masterReq  (masterReq),
    .strobe     (strobe),
    .barProgram (barProgram),
    .barAny     (barAny),
    .accessEn   (accessEn),
    .pmeN       (pmeN),
    .clkKeep    (clkKeep)
  );

  assign pwrState = state;

  AST_ACCESS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |-> (state == PS_D0U || state == PS_D0A)); // R5

endmodule

// File: tb/test_nic_pwr_ctrl.sv
module test_nic_pwr_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        barWrite = 1'b0;
  logic [1:0]  barSel = 2'd0;
  logic [31:0] barWrData = 32'd0;
  logic        pmWrite = 1'b0;
  logic [1:0]  pmStateWr = 2'd0;
  logic        pmeEnWr = 1'b0;
  logic        pmeStsClr = 1'b0;
  logic        linkChange = 1'b0;
  logic        wakeMatch = 1'b0;
  logic        busReq = 1'b0;
  logic        masterReq = 1'b0;
  logic [2:0]  pwrState;
  logic        accessEn;
  logic        pmeN;
  logic        clkKeep;

  int errors = 0;
  int checks = 0;

  // reference model state
  int mState = 0;
  bit mBar [3];
  bit mEn  = 0;
  bit mSts = 0;

  always #10 clk = ~clk;  // 50 MHz

  nic_pwr_ctrl i_nic_pwr_ctrl (
    .clk(clk), .rstN(rstN), .barWrite(barWrite), .barSel(barSel),
    .barWrData(barWrData), .pmWrite(pmWrite), .pmStateWr(pmStateWr),
    .pmeEnWr(pmeEnWr), .pmeStsClr(pmeStsClr), .linkChange(linkChange),
    .wakeMatch(wakeMatch), .busReq(busReq), .masterReq(masterReq),
    .pwrState(pwrState), .accessEn(accessEn), .pmeN(pmeN), .clkKeep(clkKeep)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit inD0;
    inD0 = (mState <= 1);
    chk("R1 state", int'(pwrState), mState);
    chk("R5 accessEn", int'(accessEn), int'(busReq && inD0));
    chk("R7 pmeN", int'(pmeN), int'(!(mSts && mEn)));
    chk("R9 clkKeep", int'(clkKeep), int'(masterReq));
  endtask

  task automatic modelStep();
    bit evt;
    bit anyBar;
    evt    = wakeMatch || (linkChange && mState != 0);
    anyBar = mBar[0] || mBar[1] || mBar[2];
    if (pmWrite) begin
      if (pmStateWr == 2'b00) begin
        if (mState >= 2) mState = anyBar ? 1 : 0;
      end else begin
        mState = int'(pmStateWr) + 1;
      end
    end else if (mState == 0 && barWrite && barSel != 2'd3 && barWrData != 0) begin
      mState = 1;
    end
    if (evt) mSts = 1;
    else if (pmWrite && pmeStsClr) mSts = 0;
    if (pmWrite) mEn = pmeEnWr;
    if (barWrite && barSel != 2'd3) mBar[barSel] = (barWrData != 0);
  endtask

  // one clock: drive on falling edge, compare, then advance model at rising edge
  task automatic cyc(input bit pw, input bit [1:0] ps, input bit en, input bit clr,
                     input bit bw, input bit [1:0] bs, input bit [31:0] bd,
                     input bit lc, input bit wm, input bit br, input bit mr);
    @(negedge clk);
    pmWrite = pw; pmStateWr = ps; pmeEnWr = en; pmeStsClr = clr;
    barWrite = bw; barSel = bs; barWrData = bd;
    linkChange = lc; wakeMatch = wm; busReq = br; masterReq = mr;
    #2;
    compareAll();
    @(posedge clk);
    modelStep();
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R2 reset state", int'(pwrState), 0);
    chk("R2 reset pmeN", int'(pmeN), 1);
    chk("R2 reset accessEn", int'(accessEn), 0);

    // D0U claims ordinary accesses
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // zero BAR write and out-of-range BAR write keep D0U
    cyc(0, 0, 0, 0, 1, 2'd0, 32'h0, 0, 0, 0, 0);
    chk("R3 zero BAR keeps D0U", int'(pwrState), 0);
    cyc(0, 0, 0, 0, 1, 2'd3, 32'h1000, 0, 0, 0, 0);
    chk("R3 invalid BAR keeps D0U", int'(pwrState), 0);
    // link change in D0U is not a wake source
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 link in D0U no wake", int'(pmeN), 1);
    // BAR programming activates
    cyc(0, 0, 0, 0, 1, 2'd1, 32'hF000_0000, 0, 0, 0, 0);
    chk("R3 BAR write to D0A", int'(pwrState), 1);
    // disable wake, then link change in D0A sets status only
    cyc(1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    chk("R7 status without enable", int'(pmeN), 1);
    cyc(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 D0 write keeps D0A", int'(pwrState), 1);
    chk("R7 enable exposes status", int'(pmeN), 0);
    cyc(1, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 clear releases pmeN", int'(pmeN), 1);
    // go to D3
    cyc(1, 2'b11, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 enter D3", int'(pwrState), 4);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 packet wake in D3", int'(pmeN), 0);
    idle(4);
    chk("R7 pmeN latched", int'(pmeN), 0);
    // clear with same-cycle event keeps status
    cyc(1, 2'b11, 1, 1, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 event beats clear", int'(pmeN), 0);
    cyc(1, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 D3 to D0A with BAR", int'(pwrState), 1);
    chk("R8 clear on return", int'(pmeN), 1);
    // D2, clear BARs, back to D0U
    cyc(1, 2'b10, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 enter D2", int'(pwrState), 3);
    cyc(0, 0, 0, 0, 1, 2'd1, 32'h0, 0, 0, 1, 0);
    chk("R3 BAR write outside D0 no change", int'(pwrState), 3);
    cyc(1, 2'b01, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 enter D1", int'(pwrState), 2);
    cyc(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 D1 to D0U without BAR", int'(pwrState), 0);
    cyc(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 D0 write keeps D0U", int'(pwrState), 0);

    // mixed stimulus, compared each cycle against the model
    for (int i = 0; i < 600; i++) begin
      bit pw;
      pw = ($urandom % 8) == 0;
      cyc(pw, 2'($urandom), 1'($urandom), 1'($urandom),
          ($urandom % 6) == 0, 2'($urandom), (($urandom % 2) == 0) ? 32'h0 : $urandom,
          ($urandom % 10) == 0, ($urandom % 12) == 0, 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule